// File: doc/BRIEF.md
# Gate Driver Desaturation Fault Sequencer

This block is the synchronous protection controller for a half-bridge gate driver with a high-side channel (index 0) and a low-side channel (index 1). Each channel receives an on/off gate command and a raw bit from an analog desaturation comparator. The block selects a gate-output mode for each channel: drive high, drive low, or high impedance.

A desaturation event is declared only when the comparator bit has stayed high long enough to pass a glitch filter and the turn-on blanking window has expired. The event starts a timed soft shutdown. During the soft shutdown the channel's gate floats, its soft pull-down is enabled, and a shared active-low status output is held low. When the soft shutdown ends, a fault latch is set. The latch holds both gates low until a clear request is accepted.

An undervoltage flag and an external hard-shutdown request also set the latch, but only while no soft shutdown is running. The filter, blanking and soft-shutdown lengths are parameters counted in clock cycles.

Top module: `gd_fault_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, both gate outputs are LOW (2'b00), both pull-down enables are 0, `ssd_busy_n` is 1 and `fault` is 0.
- R2: Gate encoding: LOW=2'b00, HIGH=2'b01, HIZ=2'b10. With no fault and no soft shutdown on a channel, that channel's gate is HIGH when its `cmd_on` bit is 1 and LOW when it is 0, in the same cycle.
- R3: A comparator assertion that lasts fewer than FILT_CYC consecutive clock edges, with the command on, never starts a soft shutdown. A run of FILT_CYC edges, after blanking, qualifies, and the pull-down rises at the following edge.
- R4: After `cmd_on` rises, no desaturation event is declared until BLANK_CYC clock edges have passed with the command held on. If desaturation is present from turn-on, the pull-down rises after edge BLANK_CYC+1 (FILT_CYC <= BLANK_CYC).
- R5: A channel whose `cmd_on` bit is 0 never starts a soft shutdown, whatever its comparator bit does.
- R6: A soft shutdown lasts exactly SSD_CYC cycles. During it, that channel's gate is HIZ (unless the fault latch is set) and its `ssd_pd_en` bit is 1.
- R7: `ssd_busy_n` is 0 exactly while at least one channel is in soft shutdown.
- R8: In the cycle after a soft shutdown ends, `ssd_busy_n` is 1 (if no other channel is in soft shutdown), `fault` is 1, and both gates are LOW. Both gates are LOW whenever `fault` is 1.
- R9: Once set, `fault` stays 1 until an accepted `fault_clr`, after which it is 0 in the next cycle.
- R10: While a soft shutdown is in progress, `uv_flag` and `ext_sd` do not set `fault`.
- R11: With no soft shutdown active, `uv_flag` or `ext_sd` sets `fault` at the next edge. No new soft shutdown starts while `fault`, `uv_flag` or `ext_sd` is 1.
- R12: `fault_clr` is ignored while `uv_flag` or `ext_sd` is 1, or while a soft shutdown is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 2 | Gate on-command per channel (bit 0 high side, bit 1 low side) |
| desat_raw | input | 2 | Raw desaturation comparator bit per channel |
| uv_flag | input | 1 | Undervoltage fault input |
| ext_sd | input | 1 | External hard-shutdown request |
| fault_clr | input | 1 | Fault-clear request |
| gate_hs | output | 2 | High-side gate mode (LOW/HIGH/HIZ) |
| gate_ls | output | 2 | Low-side gate mode (LOW/HIGH/HIZ) |
| ssd_pd_en | output | 2 | Soft pull-down enable per channel |
| ssd_busy_n | output | 1 | Active-low soft-shutdown status |
| fault | output | 1 | Shared fault latch |

## Verification
The desaturation path is driven with three directed shapes. A comparator bit held high from turn-on checks the blanking delay. A pulse one edge short of the filter length, followed by a full-length run after blanking, checks that the filter alone decides qualification. A comparator held high with the command off checks that detection is gated by the command. Undervoltage raised in the middle of a soft shutdown and clear requests raised with a hard-shutdown source present separate the masking rules from the latch rules. A long seeded random run then mixes slow command changes, bursty comparator bits and rare hard-shutdown and clear requests. It compares every output with a cycle model in the bench and reaches overlaps, such as both channels in soft shutdown at once, that the directed steps leave untried.

// File: rtl/gd_fault_pkg.sv
package gd_fault_pkg;

    typedef enum logic [1:0] {
        GATE_LOW  = 2'b00,
        GATE_HIGH = 2'b01,
        GATE_HIZ  = 2'b10
    } gate_ctl_e;

    localparam int NUM_CH = 2;

    function automatic int cnt_width(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

    // Output mode priority: latched fault, then soft shutdown, then command.
    function automatic gate_ctl_e gate_pick(input logic rst_i, input logic flt,
                                            input logic ssd, input logic cmd);
        if (rst_i || flt) return GATE_LOW;
        if (ssd)          return GATE_HIZ;
        return cmd ? GATE_HIGH : GATE_LOW;
    endfunction

endpackage

// File: rtl/gd_desat_qual.sv
module gd_desat_qual
    import gd_fault_pkg::*;
#(
    parameter int FILT_CYC  = 3,
    parameter int BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_on,
    input  logic desat_raw,
    output logic desat_ok
);
    localparam int FW = cnt_width(FILT_CYC);
    localparam int BW = cnt_width(BLANK_CYC);
    localparam logic [FW-1:0] FILT_END  = FW'(FILT_CYC);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

    logic [FW-1:0] filt_q;
    logic [BW-1:0] blank_q;

    // Blanking window: counts edges since the command turned on.
    always_ff @(posedge clk) begin
        if (rst || !cmd_on)
            blank_q <= '0;
        else if (blank_q != BLANK_END)
            blank_q <= blank_q + 1'b1;
    end

    // Glitch filter: counts consecutive edges with the comparator high.
    always_ff @(posedge clk) begin
        if (rst || !cmd_on || !desat_raw)
            filt_q <= '0;
        else if (filt_q != FILT_END)
            filt_q <= filt_q + 1'b1;
    end

    assign desat_ok = cmd_on && (blank_q == BLANK_END) && (filt_q == FILT_END);

endmodule

// File: rtl/gd_ssd_timer.sv
module gd_ssd_timer
    import gd_fault_pkg::*;
#(
    parameter int SSD_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic finish
);
    localparam int SW = cnt_width(SSD_CYC);
    localparam logic [SW-1:0] LAST = SW'(SSD_CYC - 1);

    logic [SW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (act_q) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end
    end

    assign active = act_q;
    assign finish = act_q && (cnt_q == LAST);

endmodule

// File: rtl/gd_fault_latch.sv
module gd_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic ssd_any,
    input  logic ssd_done,
    input  logic hard_req,
    input  logic clr_req,
    output logic fault
);
    logic flt_q;

    always_ff @(posedge clk) begin
        if (rst)
            flt_q <= 1'b0;
        else if (ssd_done)
            flt_q <= 1'b1;
        else if (!ssd_any && hard_req)
            flt_q <= 1'b1;
        else if (clr_req && !ssd_any && !hard_req)
            flt_q <= 1'b0;
    end

    assign fault = flt_q;

endmodule

// File: rtl/gd_fault_seq.sv
module gd_fault_seq
    import gd_fault_pkg::*;
#(
    parameter int FILT_CYC  = 3,
    parameter int BLANK_CYC = 8,
    parameter int SSD_CYC   = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_on,
    input  logic [1:0] desat_raw,
    input  logic       uv_flag,
    input  logic       ext_sd,
    input  logic       fault_clr,
    output logic [1:0] gate_hs,
    output logic [1:0] gate_ls,
    output logic [1:0] ssd_pd_en,
    output logic       ssd_busy_n,
    output logic       fault
);
    logic [NUM_CH-1:0] qual, act, fin, start;
    gate_ctl_e         gsel [NUM_CH];
    logic              hard_req, flt;

    assign hard_req = uv_flag | ext_sd;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gd_desat_qual #(.FILT_CYC(FILT_CYC), .BLANK_CYC(BLANK_CYC)) u_qual (
            .clk      (clk),
            .rst      (rst),
            .cmd_on   (cmd_on[ch]),
            .desat_raw(desat_raw[ch]),
            .desat_ok (qual[ch])
        );

        assign start[ch] = qual[ch] && !flt && !hard_req;

        gd_ssd_timer #(.SSD_CYC(SSD_CYC)) u_ssd (
            .clk   (clk),
            .rst   (rst),
            .start (start[ch]),
            .active(act[ch]),
            .finish(fin[ch])
        );

        assign gsel[ch] = gate_pick(rst, flt, act[ch], cmd_on[ch]);
    end

    gd_fault_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ssd_any (|act),
        .ssd_done(|fin),
        .hard_req(hard_req),
        .clr_req (fault_clr),
        .fault   (flt)
    );

    assign gate_hs    = gsel[0];
    assign gate_ls    = gsel[1];
    assign ssd_pd_en  = act;
    assign ssd_busy_n = ~(|act);
    assign fault      = flt;

endmodule

// File: rtl/gd_fault_seq_chk.sv
module gd_fault_seq_chk
    import gd_fault_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd_on,
    input logic       uv_flag,
    input logic       ext_sd,
    input logic [1:0] gate_hs,
    input logic [1:0] gate_ls,
    input logic [1:0] ssd_pd_en,
    input logic       ssd_busy_n,
    input logic       fault
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!fault && ssd_pd_en == 2'b00)); // R1

    AST_HIZ_HAS_PD: assert property (@(posedge clk) disable iff (rst)
        (gate_hs == 2'b10) |-> ssd_pd_en[0]); // R6

    AST_HIZ_HAS_PD_LS: assert property (@(posedge clk) disable iff (rst)
        (gate_ls == 2'b10) |-> ssd_pd_en[1]); // R6

    AST_FAULT_GATES_LOW: assert property (@(posedge clk) disable iff (rst)
        fault |-> (gate_hs == 2'b00 && gate_ls == 2'b00)); // R8

    AST_SSD_END_FAULT: assert property (@(posedge clk) disable iff (rst)
        (ssd_pd_en[0] && !ssd_busy_n) |-> ##1 (ssd_pd_en[0] || fault)); // R8

    AST_NO_SSD_CMD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!cmd_on[0] && !ssd_pd_en[0]) |=> !ssd_pd_en[0]); // R5

    AST_MASK_IN_SSD: assert property (@(posedge clk) disable iff (rst)
        (!fault && ssd_pd_en != 2'b00) |=> (!fault || ssd_pd_en != $past(ssd_pd_en))); // R10

    AST_HARD_SETS: assert property (@(posedge clk) disable iff (rst)
        (ssd_pd_en == 2'b00 && (uv_flag || ext_sd)) |=> fault); // R11

    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (fault && (uv_flag || ext_sd)) |=> fault); // R12

endmodule

bind gd_fault_seq gd_fault_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_on    (cmd_on),
    .uv_flag   (uv_flag),
    .ext_sd    (ext_sd),
    .gate_hs   (gate_hs),
    .gate_ls   (gate_ls),
    .ssd_pd_en (ssd_pd_en),
    .ssd_busy_n(ssd_busy_n),
    .fault     (fault)
);

// File: tb/gd_fault_seq_test.sv
module gd_fault_seq_test;
    localparam int FILT  = 3;
    localparam int BLANK = 8;
    localparam int SSD   = 12;
    localparam logic [1:0] LOW = 2'b00, HIGH = 2'b01, HIZ = 2'b10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd_on = '0, desat_raw = '0;
    logic       uv_flag = 1'b0, ext_sd = 1'b0, fault_clr = 1'b0;
    logic [1:0] gate_hs, gate_ls, ssd_pd_en;
    logic       ssd_busy_n, fault;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gd_fault_seq #(.FILT_CYC(FILT), .BLANK_CYC(BLANK), .SSD_CYC(SSD)) uut (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .desat_raw(desat_raw),
        .uv_flag(uv_flag), .ext_sd(ext_sd), .fault_clr(fault_clr),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .ssd_pd_en(ssd_pd_en),
        .ssd_busy_n(ssd_busy_n), .fault(fault)
    );

    // Cycle model built from the requirements
    int m_blank [2];
    int m_filt  [2];
    int m_scnt  [2];
    bit m_act   [2];
    bit m_fault;

    always @(posedge clk) begin
        bit hard, any_act, qual, fin [2], st [2];
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_blank[c] = 0; m_filt[c] = 0; m_scnt[c] = 0; m_act[c] = 0;
            end
            m_fault = 0;
        end else begin
            hard    = uv_flag | ext_sd;
            any_act = m_act[0] | m_act[1];
            for (int c = 0; c < 2; c++) begin
                qual  = cmd_on[c] && m_blank[c] == BLANK && m_filt[c] == FILT;
                fin[c] = m_act[c] && m_scnt[c] == SSD - 1;
                st[c]  = qual && !m_fault && !hard;
            end
            if (fin[0] || fin[1])               m_fault = 1;
            else if (!any_act && hard)          m_fault = 1;
            else if (fault_clr && !any_act && !hard) m_fault = 0;
            for (int c = 0; c < 2; c++) begin
                if (m_act[c]) begin
                    if (fin[c]) begin m_act[c] = 0; m_scnt[c] = 0; end
                    else m_scnt[c]++;
                end else if (st[c]) begin
                    m_act[c] = 1; m_scnt[c] = 0;
                end
                if (!cmd_on[c]) m_blank[c] = 0;
                else if (m_blank[c] != BLANK) m_blank[c]++;
                if (!cmd_on[c] || !desat_raw[c]) m_filt[c] = 0;
                else if (m_filt[c] != FILT) m_filt[c]++;
            end
        end
    end

    function automatic logic [1:0] exp_gate(int c);
        if (rst || m_fault) return LOW;
        if (m_act[c])       return HIZ;
        return cmd_on[c] ? HIGH : LOW;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk_model();
        chk("R2", "gate_hs", gate_hs, exp_gate(0));
        chk("R2", "gate_ls", gate_ls, exp_gate(1));
        chk("R6", "ssd_pd_en", ssd_pd_en, {m_act[1], m_act[0]});
        chk("R7", "ssd_busy_n", ssd_busy_n, !(m_act[0] || m_act[1]));
        chk("R9", "fault", fault, m_fault);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        // R1: reset state
        step(1);
        chk("R1", "gate_hs in reset", gate_hs, LOW);
        chk("R1", "busy_n in reset", ssd_busy_n, 1);
        rst = 0;
        step(1);
        chk("R1", "fault after reset", fault, 0);
        chk("R1", "pd after reset", ssd_pd_en, 0);

        // R2: plain command following
        cmd_on = 2'b01; #0.5;
        chk("R2", "gate_hs on", gate_hs, HIGH);
        chk("R2", "gate_ls off", gate_ls, LOW);
        cmd_on = 2'b10; #0.1;
        chk("R2", "gate_ls on", gate_ls, HIGH);
        cmd_on = 2'b00;
        step(2);

        // R4, R6, R7, R10, R8, R12, R9
        cmd_on = 2'b01; desat_raw = 2'b01;
        step(BLANK);
        chk("R4", "pd during blanking", ssd_pd_en, 0);
        step(1);
        chk("R4", "pd after blanking", ssd_pd_en, 2'b01);
        chk("R6", "gate_hs hiz", gate_hs, HIZ);
        chk("R7", "busy_n in ssd", ssd_busy_n, 0);
        uv_flag = 1;
        step(SSD - 1);
        chk("R6", "pd at last ssd cycle", ssd_pd_en, 2'b01);
        chk("R10", "fault masked by ssd", fault, 0);
        step(1);
        chk("R8", "fault after ssd", fault, 1);
        chk("R8", "busy_n released", ssd_busy_n, 1);
        chk("R8", "gate_hs low", gate_hs, LOW);
        chk("R8", "gate_ls low", gate_ls, LOW);
        fault_clr = 1;
        step(1);
        chk("R12", "clear rejected with uv", fault, 1);
        uv_flag = 0; fault_clr = 0; cmd_on = 0; desat_raw = 0;
        step(3);
        chk("R9", "fault latched", fault, 1);
        fault_clr = 1;
        step(1);
        chk("R9", "fault cleared", fault, 0);
        fault_clr = 0;

        // R3: short glitch filtered, full run qualifies
        cmd_on = 2'b01;
        step(BLANK + 2);
        desat_raw = 2'b01;
        step(FILT - 1);
        desat_raw = 2'b00;
        step(SSD + 2);
        chk("R3", "short pulse pd", ssd_pd_en, 0);
        chk("R3", "short pulse fault", fault, 0);
        desat_raw = 2'b01;
        step(FILT);
        chk("R3", "pd before filter end", ssd_pd_en, 0);
        step(1);
        chk("R3", "pd after filter", ssd_pd_en, 2'b01);
        step(SSD);
        chk("R8", "fault after filtered event", fault, 1);
        cmd_on = 0; desat_raw = 0; fault_clr = 1;
        step(1);
        fault_clr = 0;
        chk("R9", "cleared again", fault, 0);

        // R5: command off disables detection
        desat_raw = 2'b11;
        step(BLANK + FILT + 4);
        chk("R5", "pd with cmd off", ssd_pd_en, 0);
        chk("R5", "fault with cmd off", fault, 0);
        desat_raw = 0;

        // R11: external shutdown outside ssd
        cmd_on = 2'b11; ext_sd = 1;
        step(1);
        chk("R11", "fault from ext_sd", fault, 1);
        chk("R11", "gate_hs low", gate_hs, LOW);
        chk("R11", "gate_ls low", gate_ls, LOW);
        ext_sd = 0; desat_raw = 2'b11;
        step(BLANK + FILT + 3);
        chk("R11", "no ssd while fault", ssd_pd_en, 0);
        cmd_on = 0; desat_raw = 0; fault_clr = 1;
        step(1);
        fault_clr = 0;

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 24 == 0) cmd_on = 2'($urandom);
            if ($urandom % 5 == 0)  desat_raw = 2'($urandom);
            uv_flag   = ($urandom % 70 == 0);
            ext_sd    = ($urandom % 90 == 0);
            fault_clr = ($urandom % 12 == 0);
            #0.5;
            chk_model();
            step(1);
            chk_model();
        end
        finish_run();
    end
endmodule